// File: doc/BRIEF.md
# Parallel Task Delay Countdown Array

This block holds one delay record per task: a valid flag, a delayed flag and an unsigned countdown counter. Software sleeps a task by loading its record with the delayed flag set and a tick count. When software later reports that a number of system ticks has elapsed, it raises a tick command with that amount. Every valid and delayed record then subtracts the amount from its counter, all in the same clock cycle.

A record whose remaining count is used up saturates at zero and drops its delayed flag, so it becomes eligible to run. The time needed for an update does not depend on how many records exist. A write port loads one record per cycle. A write to a record takes priority over a tick arriving in the same cycle. The current state of any one record can be read back through an index. The delayed flags of all records are also presented as a vector for a neighbouring scheduler.

Top module: `dly_countdown_array`

## Requirements
- R1: After reset every record reads valid=0, delayed=0 and count=0, and `dly_vec_o` is all zero.
- R2: On a clock edge with `tick_i`=1 and amount A>0, every record with valid=1, delayed=1 and count>A holds count-A after that edge, with its delayed flag still 1.
- R3: On such a tick, a valid and delayed record with count<=A holds count=0 and delayed=0 after the edge. The counter never wraps below zero.
- R4: A tick leaves every record with valid=0 or delayed=0 unchanged, including its count.
- R5: A tick with amount 0 changes no record.
- R6: With `wr_en_i`=1, record `wr_idx_i` takes `wr_valid_i`, `wr_delayed_i` and `wr_count_i` on the next clock edge. No other record is affected by the write.
- R7: When a write and a tick occur in the same cycle, the written record takes the written values and ignores the tick. All other records apply the tick.
- R8: `rd_valid_o`, `rd_delayed_o` and `rd_count_o` show record `rd_idx_i` without delay. Bit i of `dly_vec_o` is the delayed flag of record i.
- R9: Each tick completes in one cycle, so ticks on consecutive cycles each take effect in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick command strobe |
| tick_amt_i | input | CNT_W | Number of elapsed ticks |
| wr_en_i | input | 1 | Record write strobe |
| wr_idx_i | input | IDX_W | Record to write |
| wr_valid_i | input | 1 | Valid flag to write |
| wr_delayed_i | input | 1 | Delayed flag to write |
| wr_count_i | input | CNT_W | Counter value to write |
| rd_idx_i | input | IDX_W | Record to read |
| rd_valid_o | output | 1 | Valid flag of the read record |
| rd_delayed_o | output | 1 | Delayed flag of the read record |
| rd_count_o | output | CNT_W | Counter of the read record |
| dly_vec_o | output | NUM_REC | Delayed flags of all records |

## Verification
The bench builds the block with its default parameters: 64 records and 16-bit counters. This makes record 63 and the full counter range from 0xFFFF down to zero reachable. Ticks of 0xFFFF against small counts exercise saturation at the top of the amount range. Ticks of 1 against a count of 0xFFFF exercise the plain subtract path at the other end of the range.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int unsigned DEF_NUM_REC = 64;
  localparam int unsigned DEF_CNT_W   = 16;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOAD   = 2'd1,
    ACT_SUB    = 2'd2,
    ACT_EXPIRE = 2'd3
  } cell_act_e;
endpackage

// File: rtl/dly_cell.sv
module dly_cell
  import dly_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             ld_vld_i,
  input  logic             ld_dly_i,
  input  logic [CNT_W-1:0] ld_cnt_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] tick_amt_i,
  output logic             vld_o,
  output logic             dly_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic             vld_q, dly_q;
  logic [CNT_W-1:0] cnt_q;
  cell_act_e        act;

  // load beats tick; zero amount is a no-op
  always_comb begin
    act = ACT_HOLD;
    if (ld_i) begin
      act = ACT_LOAD;
    end else if (tick_i && vld_q && dly_q && (tick_amt_i != '0)) begin
      act = (tick_amt_i >= cnt_q) ? ACT_EXPIRE : ACT_SUB;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dly_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          vld_q <= ld_vld_i;
          dly_q <= ld_dly_i;
          cnt_q <= ld_cnt_i;
        end
        ACT_SUB:    cnt_q <= cnt_q - tick_amt_i;
        ACT_EXPIRE: begin
          cnt_q <= '0;
          dly_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign vld_o = vld_q;
  assign dly_o = dly_q;
  assign cnt_o = cnt_q;

  a_r2_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && vld_q && dly_q && tick_amt_i != '0 && tick_amt_i < cnt_q)
    |=> (cnt_q == $past(cnt_q) - $past(tick_amt_i)) && dly_q);

  a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && vld_q && dly_q && tick_amt_i != '0 && tick_amt_i >= cnt_q)
    |=> (cnt_q == '0) && !dly_q);

  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && (!vld_q || !dly_q)) |=> $stable(cnt_q) && $stable(dly_q) && $stable(vld_q));

  a_r5_zero_amt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && tick_amt_i == '0) |=> $stable(cnt_q) && $stable(dly_q) && $stable(vld_q));

  a_r7_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_cnt_i)) && (dly_q == $past(ld_dly_i)) && (vld_q == $past(ld_vld_i)));

endmodule

// File: rtl/dly_rd_mux.sv
module dly_rd_mux #(
  parameter int unsigned NUM_REC = 64,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_REC)
) (
  input  logic [NUM_REC-1:0] vld_i,
  input  logic [NUM_REC-1:0] dly_i,
  input  logic [CNT_W-1:0]   cnt_i [NUM_REC],
  input  logic [IDX_W-1:0]   idx_i,
  output logic               vld_o,
  output logic               dly_o,
  output logic [CNT_W-1:0]   cnt_o
);
  // out-of-range index reads as an empty record
  always_comb begin
    vld_o = 1'b0;
    dly_o = 1'b0;
    cnt_o = '0;
    if (32'(idx_i) < NUM_REC) begin
      vld_o = vld_i[idx_i];
      dly_o = dly_i[idx_i];
      cnt_o = cnt_i[idx_i];
    end
  end
endmodule

// File: rtl/dly_countdown_array.sv
module dly_countdown_array
  import dly_pkg::*;
#(
  parameter int unsigned NUM_REC = DEF_NUM_REC,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  localparam int unsigned IDX_W  = $clog2(NUM_REC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   tick_amt_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_valid_i,
  input  logic               wr_delayed_i,
  input  logic [CNT_W-1:0]   wr_count_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic               rd_delayed_o,
  output logic [CNT_W-1:0]   rd_count_o,
  output logic [NUM_REC-1:0] dly_vec_o
);

  logic [NUM_REC-1:0] ld_vec, vld_vec, dly_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_REC];

  for (genvar g = 0; g < NUM_REC; g++) begin : g_rec
    assign ld_vec[g] = wr_en_i && (wr_idx_i == IDX_W'(g));

    dly_cell #(.CNT_W(CNT_W)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ld_i       (ld_vec[g]),
      .ld_vld_i   (wr_valid_i),
      .ld_dly_i   (wr_delayed_i),
      .ld_cnt_i   (wr_count_i),
      .tick_i     (tick_i),
      .tick_amt_i (tick_amt_i),
      .vld_o      (vld_vec[g]),
      .dly_o      (dly_vec[g]),
      .cnt_o      (cnt_arr[g])
    );
  end

  dly_rd_mux #(.NUM_REC(NUM_REC), .CNT_W(CNT_W)) u_rd (
    .vld_i (vld_vec),
    .dly_i (dly_vec),
    .cnt_i (cnt_arr),
    .idx_i (rd_idx_i),
    .vld_o (rd_valid_o),
    .dly_o (rd_delayed_o),
    .cnt_o (rd_count_o)
  );

  assign dly_vec_o = dly_vec;

  a_r6_one_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_vec) && (wr_en_i || ld_vec == '0));

  a_r3_flag_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && tick_i && tick_amt_i == '1) |=> ((dly_vec & vld_vec) == '0));

endmodule

// File: tb/dly_countdown_array_tb_top.sv
module dly_countdown_array_tb_top;
  localparam int NR = 64;
  localparam int CW = 16;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [CW-1:0] amt = '0;
  logic          wen = 1'b0;
  logic [IW-1:0] widx = '0;
  logic          wvld = 1'b0, wdly = 1'b0;
  logic [CW-1:0] wcnt = '0;
  logic [IW-1:0] ridx = '0;
  logic          rvld, rdly;
  logic [CW-1:0] rcnt;
  logic [NR-1:0] dvec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dly_countdown_array #(.NUM_REC(NR), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tick_amt_i(amt),
    .wr_en_i(wen), .wr_idx_i(widx), .wr_valid_i(wvld), .wr_delayed_i(wdly),
    .wr_count_i(wcnt), .rd_idx_i(ridx), .rd_valid_o(rvld), .rd_delayed_o(rdly),
    .rd_count_o(rcnt), .dly_vec_o(dvec)
  );

  // {idx, init count, tick amount, expected count, expected delayed}
  localparam logic [54:0] VEC [8] = '{
    {6'd0,  16'd100,    16'd30,     16'd70,     1'b1},  // R2
    {6'd5,  16'd30,     16'd30,     16'd0,      1'b0},  // R3 equal
    {6'd63, 16'hFFFF,   16'd1,      16'hFFFE,   1'b1},  // R2 top
    {6'd12, 16'd5,      16'hFFFF,   16'd0,      1'b0},  // R3 saturate
    {6'd7,  16'd1,      16'd1,      16'd0,      1'b0},  // R3
    {6'd20, 16'd1000,   16'd0,      16'd1000,   1'b1},  // R5
    {6'd33, 16'd2,      16'd1,      16'd1,      1'b1},  // R2
    {6'd40, 16'h8000,   16'h7FFF,   16'd1,      1'b1}   // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of write and/or tick; returns after the edge
  task automatic cyc(input bit w, input int idx, input bit v, input bit d,
                     input int c, input bit t, input int a);
    @(negedge clk);
    wen = w; widx = IW'(idx); wvld = v; wdly = d; wcnt = CW'(c);
    tick = t; amt = CW'(a);
    @(negedge clk);
    wen = 1'b0; tick = 1'b0; amt = '0;
  endtask

  task automatic rd(input int idx);
    ridx = IW'(idx);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0);  chk("R1 cnt", 32'(rcnt), 0); chk("R1 vld", 32'(rvld), 0); chk("R1 dly", 32'(rdly), 0);
    rd(63); chk("R1 cnt63", 32'(rcnt), 0);
    chk("R1 vec", 32'(dvec[31:0]) | 32'(dvec[63:32]), 0);

    for (int i = 0; i < 8; i++) begin
      int ix, ic, ia, ec, ed;
      ix = int'(VEC[i][54:49]); ic = int'(VEC[i][48:33]); ia = int'(VEC[i][32:17]);
      ec = int'(VEC[i][16:1]);  ed = int'(VEC[i][0]);
      cyc(1, ix, 1, 1, ic, 0, 0);
      rd(ix); chk("R6 load", 32'(rcnt), 32'(ic));
      cyc(0, 0, 0, 0, 0, 1, ia);
      rd(ix);
      chk("R2/R3/R5 cnt", 32'(rcnt), 32'(ec));
      chk("R2/R3/R5 dly", 32'(rdly), 32'(ed));
      chk("R8 vec", 32'(dvec[ix]), 32'(ed));
      cyc(1, ix, 0, 0, 0, 0, 0);
    end

    // parallel tick over mixed records
    cyc(1, 1, 1, 1, 10, 0, 0);
    cyc(1, 2, 1, 1, 20, 0, 0);
    cyc(1, 3, 1, 1, 5, 0, 0);
    cyc(1, 4, 1, 0, 50, 0, 0);
    cyc(1, 9, 0, 1, 50, 0, 0);
    rd(3); chk("R6 other intact", 32'(rcnt), 5);
    cyc(0, 0, 0, 0, 0, 1, 7);
    rd(1); chk("R2 rec1", 32'(rcnt), 3);
    rd(2); chk("R2 rec2", 32'(rcnt), 13);
    rd(3); chk("R3 rec3", 32'(rcnt), 0); chk("R3 rec3 dly", 32'(rdly), 0);
    rd(4); chk("R4 not delayed", 32'(rcnt), 50);
    rd(9); chk("R4 not valid", 32'(rcnt), 50); chk("R4 not valid dly", 32'(rdly), 1);
    chk("R8 vec", 32'(dvec[9:0]), 32'h206);

    // write collides with tick
    cyc(1, 2, 1, 1, 100, 1, 3);
    rd(2); chk("R7 load wins", 32'(rcnt), 100);
    rd(1); chk("R7 others tick", 32'(rcnt), 0); chk("R7 others dly", 32'(rdly), 0);

    // back-to-back ticks
    cyc(1, 3, 1, 1, 10, 0, 0);
    @(negedge clk);
    tick = 1'b1; amt = 16'd4;
    @(negedge clk);
    rd(3); chk("R9 first tick", 32'(rcnt), 6);
    @(negedge clk);
    tick = 1'b0; amt = '0;
    rd(3); chk("R9 second tick", 32'(rcnt), 2); chk("R9 dly", 32'(rdly), 1);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule